// File: doc/BRIEF.md
# Set-Associative Cache Controller with Way-to-RAM Mode

This block controls a small set-associative cache between a requester and external memory. It holds the tag, valid and replacement-order state for every set, along with the data ways. For each instruction fetch or data access it decides hit or miss. On a read miss it fetches one word over a request/ready port. When the miss is allowed to allocate, it writes the fetched word into the way chosen by true LRU. Writes go through to external memory. A write hit also updates the cached copy, and a write miss does not allocate.

A five-bit control register sets the cache behaviour. One bit turns the cache on. Two bits stop allocation, one for data misses and one for instruction misses. One bit changes the organisation: in its set state, ways 2 and 3 form a two-way cache, and ways 0 and 1 become a directly addressed RAM. The last bit is a purge command that clears itself. It walks the sets one per clock and clears all valid and LRU state. The block holds `busy_o` while the walk runs.

Requests are single-outstanding. A requester raises `req_i` for one cycle while `busy_o` is low, then waits for the one-cycle `ack_o` pulse. The two top address bits select a region: 00 is cacheable, 01 and 11 are cache-through (the same physical space), and 10 is the on-chip RAM window.

Top module: `cache_ctl`

## Requirements
- R1: Writing the control register with bit 4 set raises `busy_o` on the next cycle. `busy_o` stays high for exactly SETS cycles while each set's valid and LRU state is cleared, and then drops. An address cached before the purge misses afterwards.
- R2: `ctrl_rdata_o` resets to 0. Its bits read back the last written values: bit 0 cache enable, bit 1 instruction no-allocate, bit 2 data no-allocate, bit 3 two-way mode. Bit 4 always reads 0.
- R3: With bit 0 clear, every access goes to external memory with `hit_o`=0, and nothing is allocated. After enabling, an address read while the cache was disabled still misses once.
- R4: In four-way mode a set holds four distinct tags. A repeated read of a cached address returns its data with `hit_o`=1 and no external transfer.
- R5: A read miss into a full set replaces the least recently used way. Every hit and every fill makes the touched way most recent.
- R6: With bit 3 set, lookups never hit in ways 0 or 1, even for lines they held before the mode change. Each set then caches two tags, in ways 2 and 3, with LRU replacement between them.
- R7: With bit 3 set, a region-10 access reads or writes RAM word (way `addr[4]`, index `addr[3:0]`) with `hit_o`=1 and no external transfer, and cache fills leave it unchanged. With bit 3 clear, region 10 is passed to external memory uncached.
- R8: With bit 2 set and the cache enabled, a data read miss returns the fetched word but does not allocate. Data and instruction hits are still served.
- R9: With bit 1 set and the cache enabled, an instruction-fetch miss (`ifetch_i`=1, always a read) does not allocate. Data misses still allocate, and instruction hits are still served.
- R10: Region 01 and 11 accesses never hit and never allocate. They reach external memory at the same physical address (`addr[13:0]`) as the matching cacheable access.
- R11: Every data write goes to external memory. A write hit updates the cached word and reports `hit_o`=1. A write miss does not allocate.
- R12: `mem_req_o` stays high, with stable address, write flag and write data, until `mem_ready_i`. `ack_o` is a single-cycle pulse carrying `rdata_o` and `hit_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 5 | Control register write value |
| ctrl_rdata_o | output | 5 | Control register read value |
| req_i | input | 1 | Access request, taken when busy_o is low |
| we_i | input | 1 | Write access (ignored when ifetch_i is 1) |
| ifetch_i | input | 1 | Access is an instruction fetch |
| addr_i | input | ADDR_W | Word address, top two bits select region |
| wdata_i | input | DATA_W | Write data |
| busy_o | output | 1 | Access in progress or purge running |
| ack_o | output | 1 | Access complete, one-cycle pulse |
| hit_o | output | 1 | Access found in cache or RAM window |
| rdata_o | output | DATA_W | Read data, valid with ack_o |
| mem_req_o | output | 1 | External transfer request |
| mem_we_o | output | 1 | External transfer is a write |
| mem_addr_o | output | ADDR_W-2 | External physical word address |
| mem_wdata_o | output | DATA_W | External write data |
| mem_ready_i | input | 1 | External transfer complete |
| mem_rdata_i | input | DATA_W | External read data |

## Verification
The bench fills one set with five tags and checks which one was evicted. A design with a broken order vector would evict the wrong way, and a survivor would miss. After a mode switch with no purge, it re-reads a line that still sits valid in way 0; a lookup that ignored the mode mask would hit there. It also counts the cycles of the purge walk, writes the RAM window and then refills the same set, and repeats misses under each no-allocate bit. An off-by-one walker, a fill that strays into ways 0 or 1, or a no-allocate bit wired to the wrong access type each shows up as a wrong count, wrong data or wrong hit flag.

// File: rtl/cache_ctl_pkg.sv
package cache_ctl_pkg;
  localparam int WAYS = 4;
  localparam int ORD_W = 6;

  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_MEM} st_e;
  typedef enum logic [1:0] {RG_CACHE = 2'b00, RG_THRU = 2'b01, RG_RAM = 2'b10, RG_THRU2 = 2'b11} region_e;

  typedef struct packed {
    logic two;
    logic dna;
    logic ina;
    logic en;
  } cfg_t;
endpackage

// File: rtl/cache_cfg.sv
module cache_cfg import cache_ctl_pkg::*; #(
  parameter int SETS  = 16,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [4:0]       wdata_i,
  input  logic             idle_i,
  output cfg_t             cfg_o,
  output logic [4:0]       rdata_o,
  output logic             run_o,
  output logic             clr_o,
  output logic [IDX_W-1:0] clr_idx_o
);
  cfg_t             cfg_q;
  logic             run_q;
  logic [IDX_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (run_q && idle_i) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == IDX_W'(SETS - 1)) run_q <= 1'b0;
      end
      if (we_i) begin
        cfg_q <= wdata_i[3:0];
        if (wdata_i[4]) begin
          run_q <= 1'b1;
          cnt_q <= '0;
        end
      end
    end
  end

  assign cfg_o     = cfg_q;
  assign rdata_o   = {1'b0, cfg_q};
  assign run_o     = run_q;
  assign clr_o     = run_q && idle_i;
  assign clr_idx_o = cnt_q;
endmodule

// File: rtl/cache_match.sv
module cache_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 10,
  localparam int WW   = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            vld_i,
  input  logic [WAYS-1:0]            mask_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic                       hit_o,
  output logic [WW-1:0]              way_o
);
  logic [WAYS-1:0] eq;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign eq[w] = vld_i[w] && mask_i[w] && (tags_i[w] == tag_i);
  end

  always_comb begin
    hit_o = |eq;
    way_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (eq[w]) way_o = WW'(w);
  end
endmodule

// File: rtl/cache_lru.sv
module cache_lru import cache_ctl_pkg::*; (
  input  logic [ORD_W-1:0] ord_i,
  input  logic             two_i,
  input  logic [1:0]       touch_i,
  output logic [1:0]       victim_o,
  output logic [ORD_W-1:0] ord_o
);
  // bit for pair (i,j), i<j: 1 = way i more recent than way j
  function automatic int unsigned pos(int unsigned i, int unsigned j);
    return (i == 0) ? j - 1 : (i == 1) ? j + 1 : 5;
  endfunction

  logic [3:0] oldest;

  always_comb begin
    ord_o  = ord_i;
    oldest = '1;
    for (int unsigned i = 0; i < 4; i++) begin
      for (int unsigned j = i + 1; j < 4; j++) begin
        if (touch_i == 2'(i))      ord_o[pos(i, j)] = 1'b1;
        else if (touch_i == 2'(j)) ord_o[pos(i, j)] = 1'b0;
        if (ord_i[pos(i, j)]) oldest[i] = 1'b0;
        else                  oldest[j] = 1'b0;
      end
    end
  end

  always_comb begin
    if (two_i)          victim_o = ord_i[5] ? 2'd3 : 2'd2;
    else if (oldest[0]) victim_o = 2'd0;
    else if (oldest[1]) victim_o = 2'd1;
    else if (oldest[2]) victim_o = 2'd2;
    else                victim_o = 2'd3;
  end
endmodule

// File: rtl/cache_ctl.sv
module cache_ctl import cache_ctl_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SETS   = 16,
  localparam int IDX_W = $clog2(SETS),
  localparam int PA_W  = ADDR_W - 2,
  localparam int TAG_W = PA_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [4:0]        ctrl_wdata_i,
  output logic [4:0]        ctrl_rdata_o,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              ifetch_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              ack_o,
  output logic              hit_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [PA_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  st_e               st_q;
  logic [ADDR_W-1:0] r_addr;
  logic              r_we, r_if;
  logic [DATA_W-1:0] r_wd;

  logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];
  logic [WAYS-1:0]            vld_q [SETS];
  logic [ORD_W-1:0]           ord_q [SETS];
  logic [DATA_W-1:0]          dat_q [WAYS][SETS];

  cfg_t             cfg;
  logic             purge_run, purge_clr;
  logic [IDX_W-1:0] purge_idx;

  cache_cfg #(.SETS(SETS)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(ctrl_we_i), .wdata_i(ctrl_wdata_i), .idle_i(st_q == ST_IDLE),
    .cfg_o(cfg), .rdata_o(ctrl_rdata_o),
    .run_o(purge_run), .clr_o(purge_clr), .clr_idx_o(purge_idx)
  );

  region_e          rg;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic [1:0]       ram_way, hit_way, victim, touch;
  logic             wr, look, ram_sel, hit_any, hit_c, alloc;
  logic             in_look, mem_done, upd_ord, fill;
  logic [ORD_W-1:0] ord_nxt;

  assign rg      = region_e'(r_addr[ADDR_W-1 -: 2]);
  assign idx     = r_addr[IDX_W-1:0];
  assign tag     = r_addr[PA_W-1:IDX_W];
  assign ram_way = {1'b0, r_addr[IDX_W]};
  assign wr      = r_we && !r_if;
  assign look    = cfg.en && (rg == RG_CACHE);
  assign ram_sel = cfg.two && (rg == RG_RAM);

  cache_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .vld_i(vld_q[idx]), .mask_i(cfg.two ? 4'b1100 : 4'b1111),
    .tags_i(tag_q[idx]), .tag_i(tag),
    .hit_o(hit_any), .way_o(hit_way)
  );

  assign hit_c = look && hit_any;
  assign touch = hit_c ? hit_way : victim;

  cache_lru u_lru (
    .ord_i(ord_q[idx]), .two_i(cfg.two), .touch_i(touch),
    .victim_o(victim), .ord_o(ord_nxt)
  );

  assign alloc    = look && !wr && !(r_if ? cfg.ina : cfg.dna);
  assign in_look  = (st_q == ST_LOOK);
  assign mem_done = (st_q == ST_MEM) && mem_ready_i;
  assign fill     = mem_done && alloc && !hit_c;
  assign upd_ord  = (in_look && hit_c && !wr) || (mem_done && (hit_c || alloc));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      r_addr  <= '0;
      r_we    <= 1'b0;
      r_if    <= 1'b0;
      r_wd    <= '0;
      ack_o   <= 1'b0;
      hit_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      ack_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_i && !busy_o) begin
          r_addr <= addr_i;
          r_we   <= we_i;
          r_if   <= ifetch_i;
          r_wd   <= wdata_i;
          st_q   <= ST_LOOK;
        end
        ST_LOOK: begin
          if (ram_sel) begin
            ack_o   <= 1'b1;
            hit_o   <= 1'b1;
            rdata_o <= dat_q[ram_way][idx];
            st_q    <= ST_IDLE;
          end else if (hit_c && !wr) begin
            ack_o   <= 1'b1;
            hit_o   <= 1'b1;
            rdata_o <= dat_q[hit_way][idx];
            st_q    <= ST_IDLE;
          end else begin
            st_q <= ST_MEM;
          end
        end
        ST_MEM: if (mem_ready_i) begin
          ack_o   <= 1'b1;
          hit_o   <= hit_c;
          rdata_o <= mem_rdata_i;
          st_q    <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        ord_q[s] <= '0;
      end
    end else begin
      if (purge_clr) begin
        vld_q[purge_idx] <= '0;
        ord_q[purge_idx] <= '0;
      end else if (upd_ord) begin
        ord_q[idx] <= ord_nxt;
      end
      if (fill) vld_q[idx][victim] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (in_look && ram_sel && wr) dat_q[ram_way][idx] <= r_wd;
    if (mem_done && hit_c && wr)  dat_q[hit_way][idx] <= r_wd;
    if (fill) begin
      dat_q[victim][idx] <= mem_rdata_i;
      tag_q[idx][victim] <= tag;
    end
  end

  assign busy_o      = (st_q != ST_IDLE) || purge_run;
  assign mem_req_o   = (st_q == ST_MEM);
  assign mem_we_o    = wr;
  assign mem_addr_o  = r_addr[PA_W-1:0];
  assign mem_wdata_o = r_wd;
endmodule

// File: rtl/cache_ctl_chk.sv
module cache_ctl_chk #(
  parameter int PA_W = 14
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ctrl_we_i,
  input logic [4:0]      ctrl_wdata_i,
  input logic [4:0]      ctrl_rdata_o,
  input logic            busy_o,
  input logic            ack_o,
  input logic            hit_o,
  input logic            mem_req_o,
  input logic            mem_we_o,
  input logic [PA_W-1:0] mem_addr_o,
  input logic            mem_ready_i
);
  AST_PURGE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i && ctrl_wdata_i[4] |=> busy_o); // R1
  AST_CFG_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> ctrl_rdata_o[3:0] == $past(ctrl_wdata_i[3:0])); // R2
  AST_MISS_HAS_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o && !hit_o |-> $past(mem_req_o && mem_ready_i)); // R3
  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o); // R12
  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R12
  AST_MEM_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o); // R12
endmodule

bind cache_ctl cache_ctl_chk #(.PA_W(PA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_we_i(ctrl_we_i), .ctrl_wdata_i(ctrl_wdata_i),
  .ctrl_rdata_o(ctrl_rdata_o), .busy_o(busy_o), .ack_o(ack_o), .hit_o(hit_o),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .mem_ready_i(mem_ready_i)
);

// File: tb/cache_ctl_tb.sv
module cache_ctl_tb;
  localparam int ADDR_W = 16, DATA_W = 32, SETS = 16, PA_W = 14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctrl_we = 1'b0;
  logic [4:0] ctrl_wdata = '0, ctrl_rdata;
  logic req = 1'b0, we = 1'b0, ifetch = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0, rdata;
  logic busy, ack, hit;
  logic mem_req, mem_we, mem_ready = 1'b0;
  logic [PA_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata = '0;

  always #10 clk = ~clk;

  cache_ctl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
    .ctrl_rdata_o(ctrl_rdata), .req_i(req), .we_i(we), .ifetch_i(ifetch),
    .addr_i(addr), .wdata_i(wdata), .busy_o(busy), .ack_o(ack), .hit_o(hit),
    .rdata_o(rdata), .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata)
  );

  typedef struct { logic [31:0] d; logic h; logic cd; } exp_t;
  exp_t  q[$];
  string rq[$];
  int n_tests = 0, n_fail = 0, ext_cnt = 0, done_cnt = 0, wait_cnt = 0;
  logic tw = 1'b0;
  logic [31:0] mm [int];
  logic [31:0] ram_ref [int];

  function automatic logic [31:0] memval(int a);
    if (mm.exists(a)) return mm[a];
    return 32'hC0DE0000 ^ (a * 32'h9E37);
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string r, input string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  // external memory model: two wait cycles per transfer
  always @(negedge clk) begin
    if (mem_ready) mem_ready = 1'b0;
    else if (rst_n && mem_req) begin
      wait_cnt++;
      if (wait_cnt >= 2) begin
        wait_cnt = 0;
        ext_cnt++;
        if (mem_we) mm[int'(mem_addr)] = mem_wdata;
        else mem_rdata = memval(int'(mem_addr));
        mem_ready = 1'b1;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && ack) begin
      if (q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R12 unexpected ack: actual 1 expected 0");
      end else begin
        exp_t e;
        string r;
        e = q.pop_front();
        r = rq.pop_front();
        chk(32'(hit), 32'(e.h), r, "hit");
        if (e.cd) chk(rdata, e.d, r, "rdata");
      end
      done_cnt++;
    end
  end

  task automatic acc(input logic [15:0] a, input logic w, input logic f,
                     input logic [31:0] wd, input logic eh, input string r);
    exp_t e;
    int tgt;
    e.h = eh; e.cd = !(w && !f); e.d = '0;
    if (a[15:14] == 2'b10 && tw) begin
      if (!e.cd) ram_ref[int'({a[4], a[3:0]})] = wd;
      else e.d = ram_ref[int'({a[4], a[3:0]})];
    end else if (e.cd) e.d = memval(int'(a[13:0]));
    q.push_back(e); rq.push_back(r);
    tgt = done_cnt + 1;
    while (busy) @(negedge clk);
    req = 1'b1; addr = a; we = w; ifetch = f; wdata = wd;
    @(negedge clk);
    req = 1'b0;
    while (done_cnt < tgt) @(negedge clk);
  endtask

  task automatic rd(input logic [15:0] a, input logic eh, input string r);
    acc(a, 1'b0, 1'b0, '0, eh, r);
  endtask
  task automatic fe(input logic [15:0] a, input logic eh, input string r);
    acc(a, 1'b0, 1'b1, '0, eh, r);
  endtask
  task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic eh, input string r);
    acc(a, 1'b1, 1'b0, d, eh, r);
  endtask

  task automatic cw(input logic [4:0] v);
    ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 1'b0;
    tw = v[3];
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  localparam logic [15:0] A = 16'h0013, B = 16'h0023, C = 16'h0033, D = 16'h0043;
  localparam logic [15:0] E = 16'h0053, F = 16'h0063, G = 16'h0015, H = 16'h0016;

  initial begin
    int e0, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(32'(ctrl_rdata), 0, "R2", "reset ctrl");
    chk(32'(busy), 0, "R3", "reset busy");
    chk(32'(mem_req), 0, "R12", "reset mem_req");

    // R3 disabled: all external
    e0 = ext_cnt;
    rd(A, 1'b0, "R3"); rd(A, 1'b0, "R3");
    chk(32'(ext_cnt - e0), 2, "R3", "ext count disabled");

    cw(5'h01);
    chk(32'(ctrl_rdata), 32'h01, "R2", "ctrl readback");
    rd(A, 1'b0, "R3");
    e0 = ext_cnt;
    rd(A, 1'b1, "R4");
    chk(32'(ext_cnt - e0), 0, "R4", "ext count on hit");

    // R4 / R5 four ways, LRU
    rd(B, 1'b0, "R4"); rd(C, 1'b0, "R4"); rd(D, 1'b0, "R4");
    rd(B, 1'b1, "R4"); rd(C, 1'b1, "R4"); rd(D, 1'b1, "R4"); rd(A, 1'b1, "R4");
    rd(E, 1'b0, "R5");
    rd(A, 1'b1, "R5");
    rd(B, 1'b0, "R5");
    rd(D, 1'b1, "R5");

    // R11 write-through
    e0 = ext_cnt;
    wr(A, 32'h1111_2222, 1'b1, "R11");
    chk(32'(ext_cnt - e0), 1, "R11", "write hit goes external");
    rd(A, 1'b1, "R11");
    wr(F, 32'h3333_4444, 1'b0, "R11");
    rd(F, 1'b0, "R11");

    // R10 cache-through region, same physical word as A
    e0 = ext_cnt;
    rd(16'h4013, 1'b0, "R10");
    rd(16'h4013, 1'b0, "R10");
    rd(16'hC013, 1'b0, "R10");
    chk(32'(ext_cnt - e0), 3, "R10", "through region external");

    // R8 data no-allocate
    cw(5'h05);
    rd(G, 1'b0, "R8"); rd(G, 1'b0, "R8");
    rd(A, 1'b1, "R8");
    fe(G, 1'b0, "R8"); fe(G, 1'b1, "R8");

    // R9 instruction no-allocate
    cw(5'h03);
    fe(H, 1'b0, "R9"); fe(H, 1'b0, "R9");
    rd(H, 1'b0, "R9"); fe(H, 1'b1, "R9");

    // R1 purge walk
    ctrl_we = 1'b1; ctrl_wdata = 5'h11;
    @(negedge clk);
    ctrl_we = 1'b0; tw = 1'b0;
    chk(32'(busy), 1, "R1", "busy after purge write");
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk(32'(n), SETS, "R1", "purge cycles");
    chk(32'(ctrl_rdata), 32'h01, "R2", "purge bit reads 0");
    rd(A, 1'b0, "R1");
    rd(H, 1'b0, "R1");

    // R6 two-way mode without purge: A still valid in way 0
    cw(5'h09);
    rd(A, 1'b0, "R6");
    rd(A, 1'b1, "R6");
    rd(B, 1'b0, "R6");
    rd(A, 1'b1, "R6");
    rd(C, 1'b0, "R6");
    rd(A, 1'b1, "R6");
    rd(B, 1'b0, "R6");

    // R7 RAM window
    e0 = ext_cnt;
    wr(16'h8003, 32'hAAAA_0001, 1'b1, "R7");
    wr(16'h8013, 32'hBBBB_0002, 1'b1, "R7");
    rd(16'h8003, 1'b1, "R7");
    rd(16'h8013, 1'b1, "R7");
    chk(32'(ext_cnt - e0), 0, "R7", "RAM no external");
    rd(D, 1'b0, "R7"); rd(E, 1'b0, "R7");
    rd(16'h8003, 1'b1, "R7");
    rd(16'h8013, 1'b1, "R7");

    cw(5'h01);
    e0 = ext_cnt;
    rd(16'h8003, 1'b0, "R7");
    chk(32'(ext_cnt - e0), 1, "R7", "window external in four-way");

    repeat (4) @(negedge clk);
    chk(32'(q.size()), 0, "R12", "scoreboard drained");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule